// File: doc/BRIEF.md
# Frames Out of Sync Counter

This block keeps a saturating performance count for the receive side of a T1/E1 framer. It reports on synchronization quality. What it counts depends on the line type and on a mode select. In T1 primary operation it counts the multiframes in which the receive synchronizer was out of sync. It samples the sync status once at each multiframe boundary strobe. In T1 alternate operation it counts framing-pattern errors: Ft errors when the framing is D4 and FPS errors when it is ESF. In E1 it counts errored frame alignment words in time slot 0.

Out-of-sync multiframes are still counted while receive loss of frame is asserted. Framing-pattern errors and FAS word errors are not. E1 FAS errors are also ignored while the framer is hunting for FAS alignment or for CAS or CRC-4 multiframe sync. A latch strobe copies the live count into a holding register and restarts the live count. The holding register is presented as a high half and a low half. Any change of the effective counting mode clears the live count, so counts taken under different modes are never mixed.

Top module: `frame_sync_counter`

## Requirements
- R1: After reset, both the holding register and the live count are zero, so cntHigh and cntLow read 0.
- R2: T1 out-of-sync mode (lineE1=0, altMode=0): the live count rises by one on each clock where mfStrobe=1 and outOfSync=1. A high outOfSync without mfStrobe adds nothing, and ftErr, fpsErr and fasErr are ignored.
- R3: In T1 out-of-sync mode, rxLof has no effect on counting.
- R4: T1 alternate mode with D4 framing (lineE1=0, altMode=1, esfMode=0): each clock with ftErr=1 adds one. fpsErr, mfStrobe, outOfSync and fasErr are ignored.
- R5: T1 alternate mode with ESF framing (lineE1=0, altMode=1, esfMode=1): each clock with fpsErr=1 adds one. ftErr, mfStrobe, outOfSync and fasErr are ignored.
- R6: In T1 alternate mode, no event is counted on a clock where rxLof=1.
- R7: E1 mode (lineE1=1, with altMode and esfMode don't care): each clock with fasErr=1 and rxLof=0 adds one. All T1 strobes are ignored.
- R8: In E1 mode, fasErr is not counted on a clock where fasSearch=1 or mfSearch=1.
- R9: On a clock with latchStb=1, the holding register takes the live count. cntHigh carries its upper CNT_W/2 bits and cntLow its lower CNT_W/2 bits. The live count restarts at 1 if an event is counted on that clock and at 0 otherwise. The holding register changes only on a latch.
- R10: The live count stops at all ones (0xFFFF by default) and never wraps.
- R11: A change of effective mode clears the live count on the next clock, and an event presented on that clock is dropped. The effective modes are T1 out-of-sync, T1 D4 alternate, T1 ESF alternate and E1. esfMode changes in T1 out-of-sync mode, and altMode or esfMode changes in E1, are not mode changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineE1 | input | 1 | 1 = E1 line, 0 = T1 line |
| altMode | input | 1 | T1 only: 1 = count framing-pattern errors, 0 = count out-of-sync multiframes |
| esfMode | input | 1 | T1 framing: 1 = ESF, 0 = D4 |
| mfStrobe | input | 1 | Multiframe boundary strobe |
| outOfSync | input | 1 | Receive synchronizer out of sync |
| ftErr | input | 1 | Ft pattern error strobe |
| fpsErr | input | 1 | FPS pattern error strobe |
| fasErr | input | 1 | E1 FAS word error strobe |
| rxLof | input | 1 | Receive loss of frame |
| fasSearch | input | 1 | E1 framer searching for FAS alignment |
| mfSearch | input | 1 | E1 framer searching for CAS or CRC-4 multiframe sync |
| latchStb | input | 1 | Transfer live count to holding register and restart it |
| cntHigh | output | CNT_W/2 | Upper half of the held count |
| cntLow | output | CNT_W/2 | Lower half of the held count |

## Verification
The bench builds the block with CNT_W=6, so the count saturates at 63 and each half is 3 bits. That brings saturation into reach in a few dozen cycles, and a sweep can also cover boundaries that span both halves. In each of the four effective modes, the bench applies all 256 combinations of the eight event and status inputs. It latches after every 16 combinations and compares the result with an arithmetic model of which combinations should count. Directed cases cover a latch that coincides with an event, mode changes that do and do not clear the count, and the stop at all ones.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    MODE_T1_OOS = 2'd0,
    MODE_T1_FT  = 2'd1,
    MODE_T1_FPS = 2'd2,
    MODE_E1     = 2'd3
  } fscMode_e;

  typedef struct packed {
    logic inc;
    logic clr;
    logic latch;
  } fscStrobe_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineE1,
  input  logic       altMode,
  input  logic       esfMode,
  input  logic       mfStrobe,
  input  logic       outOfSync,
  input  logic       ftErr,
  input  logic       fpsErr,
  input  logic       fasErr,
  input  logic       rxLof,
  input  logic       fasSearch,
  input  logic       mfSearch,
  input  logic       latchStb,
  output fscStrobe_t stb
);
  fscMode_e modeNow;
  fscMode_e modePrev;
  logic     eventHit;

  always_comb begin
    if (lineE1)        modeNow = MODE_E1;
    else if (!altMode) modeNow = MODE_T1_OOS;
    else if (esfMode)  modeNow = MODE_T1_FPS;
    else               modeNow = MODE_T1_FT;
  end

  always_comb begin
    unique case (modeNow)
      MODE_T1_OOS: eventHit = mfStrobe & outOfSync;
      MODE_T1_FT:  eventHit = ftErr & ~rxLof;
      MODE_T1_FPS: eventHit = fpsErr & ~rxLof;
      MODE_E1:     eventHit = fasErr & ~rxLof & ~fasSearch & ~mfSearch;
      default:     eventHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) modePrev <= MODE_T1_OOS;
    else       modePrev <= modeNow;
  end

  always_comb begin
    stb.clr   = (modeNow != modePrev);
    stb.inc   = eventHit;
    stb.latch = latchStb;
  end

  // R6 / R7: loss of frame blocks counting outside out-of-sync mode
  a_r6_lof_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (rxLof && (lineE1 || altMode)) |-> !stb.inc);

  // R2: out-of-sync counting only at a multiframe boundary
  a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    (!lineE1 && !altMode && stb.inc) |-> mfStrobe);

  // R8: E1 search states block counting
  a_r8_search_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (lineE1 && (fasSearch || mfSearch)) |-> !stb.inc);
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fscStrobe_t       stb,
  output logic [CNT_W-1:0] holdCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] liveCnt;
  logic [CNT_W-1:0] restartVal;

  assign restartVal = stb.inc ? CNT_ONE : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCnt <= '0;
      holdCnt <= '0;
    end else begin
      if (stb.latch) holdCnt <= liveCnt;
      if (stb.clr)
        liveCnt <= '0;
      else if (stb.latch)
        liveCnt <= restartVal;
      else if (stb.inc && liveCnt != CNT_MAX)
        liveCnt <= liveCnt + CNT_ONE;
    end
  end

  // R10: count stays at all ones
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == CNT_MAX && !stb.clr && !stb.latch) |=> liveCnt == CNT_MAX);

  // R2: live count moves by at most one step between latches
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clr && !stb.latch) |=>
      (liveCnt == $past(liveCnt) || liveCnt == $past(liveCnt) + CNT_ONE));

  // R11: mode change empties the live count
  a_r11_mode_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> liveCnt == '0);

  // R9: latch transfers the live count
  a_r9_transfer: assert property (@(posedge clk) disable iff (!rstN)
    stb.latch |=> holdCnt == $past(liveCnt));

  // R9: holding register changes only on latch
  a_r9_hold_steady: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch |=> $stable(holdCnt));
endmodule

// File: rtl/frame_sync_counter.sv
module frame_sync_counter
  import fsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineE1,
  input  logic                 altMode,
  input  logic                 esfMode,
  input  logic                 mfStrobe,
  input  logic                 outOfSync,
  input  logic                 ftErr,
  input  logic                 fpsErr,
  input  logic                 fasErr,
  input  logic                 rxLof,
  input  logic                 fasSearch,
  input  logic                 mfSearch,
  input  logic                 latchStb,
  output logic [CNT_W/2-1:0]   cntHigh,
  output logic [CNT_W/2-1:0]   cntLow
);
  localparam int HALF_W = CNT_W / 2;

  fscStrobe_t       stb;
  logic [CNT_W-1:0] holdCnt;

  fsc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .lineE1(lineE1), .altMode(altMode),
    .esfMode(esfMode), .mfStrobe(mfStrobe), .outOfSync(outOfSync),
    .ftErr(ftErr), .fpsErr(fpsErr), .fasErr(fasErr), .rxLof(rxLof),
    .fasSearch(fasSearch), .mfSearch(mfSearch), .latchStb(latchStb),
    .stb(stb)
  );

  fsc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .holdCnt(holdCnt)
  );

  assign cntHigh = holdCnt[CNT_W-1:HALF_W];
  assign cntLow  = holdCnt[HALF_W-1:0];
endmodule

// File: tb/frame_sync_counter_tb_top.sv
module frame_sync_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;
  localparam int HALF_W = CNT_W / 2;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineE1 = 0, altMode = 0, esfMode = 0;
  logic mfStrobe = 0, outOfSync = 0, ftErr = 0, fpsErr = 0, fasErr = 0;
  logic rxLof = 0, fasSearch = 0, mfSearch = 0, latchStb = 0;
  logic [HALF_W-1:0] cntHigh, cntLow;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_sync_counter #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .lineE1(lineE1), .altMode(altMode),
    .esfMode(esfMode), .mfStrobe(mfStrobe), .outOfSync(outOfSync),
    .ftErr(ftErr), .fpsErr(fpsErr), .fasErr(fasErr), .rxLof(rxLof),
    .fasSearch(fasSearch), .mfSearch(mfSearch), .latchStb(latchStb),
    .cntHigh(cntHigh), .cntLow(cntLow)
  );

  // bit order of an event word: 0 mfStrobe, 1 outOfSync, 2 ftErr, 3 fpsErr,
  // 4 fasErr, 5 rxLof, 6 fasSearch, 7 mfSearch
  function automatic bit expCount(int m, logic [7:0] c);
    case (m)
      0: return c[0] && c[1];                       // R2, R3
      1: return c[2] && !c[5];                      // R4, R6
      2: return c[3] && !c[5];                      // R5, R6
      default: return c[4] && !c[5] && !c[6] && !c[7]; // R7, R8
    endcase
  endfunction

  task automatic check(string req, int actual, int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic drive(logic [7:0] c, logic lat);
    {mfSearch, fasSearch, rxLof, fasErr, fpsErr, ftErr, outOfSync, mfStrobe} = c;
    latchStb = lat;
    @(negedge clk);
    {mfSearch, fasSearch, rxLof, fasErr, fpsErr, ftErr, outOfSync, mfStrobe} = '0;
    latchStb = 1'b0;
  endtask

  task automatic readCount(output int v);
    drive(8'h00, 1'b1);
    v = {cntHigh, cntLow};
  endtask

  task automatic setMode(int m);
    lineE1  = (m == 3);
    altMode = (m == 1 || m == 2);
    esfMode = (m == 2);
    drive(8'h00, 1'b0);
  endtask

  initial begin
    int v;
    int exp;
    string tag;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {cntHigh, cntLow}, 0);
    rstN = 1'b1;
    @(negedge clk);
    readCount(v);
    check("R1 live count after reset", v, 0);

    // sweeps in each mode
    for (int m = 0; m < 4; m++) begin
      case (m)
        0: tag = "R2 R3 out-of-sync sweep";
        1: tag = "R4 R6 D4 Ft sweep";
        2: tag = "R5 R6 ESF FPS sweep";
        default: tag = "R7 R8 E1 FAS sweep";
      endcase
      setMode(m);
      readCount(v);
      for (int g = 0; g < 16; g++) begin
        exp = 0;
        for (int k = 0; k < 16; k++) begin
          logic [7:0] c;
          c = 8'(g * 16 + k);
          if (expCount(m, c)) exp++;
          drive(c, 1'b0);
        end
        readCount(v);
        check(tag, v, exp);
      end
    end

    // R9: latch coincident with event restarts at one
    setMode(0);
    readCount(v);
    drive(8'h03, 1'b0);
    drive(8'h03, 1'b0);
    drive(8'h03, 1'b1);
    check("R9 latched value", v + 0 == v ? {cntHigh, cntLow} : 0, 2);
    readCount(v);
    check("R9 restart at one", v, 1);

    // R9: halves placement
    for (int i = 0; i < 13; i++) drive(8'h03, 1'b0);
    readCount(v);
    check("R9 high half", cntHigh, 13 >> HALF_W);
    check("R9 low half", cntLow, 13 & ((1 << HALF_W) - 1));

    // R10: saturation
    for (int i = 0; i < CNT_MAX + 10; i++) drive(8'h03, 1'b0);
    readCount(v);
    check("R10 saturate", v, CNT_MAX);

    // R11: mode change clears, change-cycle event dropped
    for (int i = 0; i < 5; i++) drive(8'h03, 1'b0);
    lineE1 = 1'b1;
    drive(8'h10, 1'b0);
    drive(8'h10, 1'b0);
    drive(8'h10, 1'b0);
    readCount(v);
    check("R11 clear on mode change", v, 2);

    // R11: altMode/esfMode in E1 are not mode changes
    drive(8'h10, 1'b0);
    altMode = 1'b1; esfMode = 1'b1;
    drive(8'h10, 1'b0);
    readCount(v);
    check("R11 E1 ignores alt/esf", v, 2);

    // R11: esfMode change in out-of-sync mode keeps count
    setMode(0);
    readCount(v);
    for (int i = 0; i < 3; i++) drive(8'h03, 1'b0);
    esfMode = 1'b1;
    drive(8'h03, 1'b0);
    drive(8'h03, 1'b0);
    readCount(v);
    check("R11 esf toggle in out-of-sync mode", v, 5);

    // R11: D4 to ESF alternate is a change
    setMode(1);
    readCount(v);
    for (int i = 0; i < 4; i++) drive(8'h04, 1'b0);
    esfMode = 1'b1;
    drive(8'h08, 1'b0);
    drive(8'h08, 1'b0);
    readCount(v);
    check("R11 D4 to ESF clears", v, 1);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule